// File: doc/BRIEF.md
# Adaptive Baseline Window Tracker

This block watches a free-running stream of unsigned ADC samples and decides, sample by sample, whether each one belongs to the quiet baseline or to an event. The decision uses a window that extends the same distance above and below a running baseline estimate. The half-width of that window follows the noise. It widens by one lsb after a fixed number of samples have landed outside the window. It narrows by one lsb after a larger, separately counted number have landed inside. Widening after fewer samples than narrowing lets the window recapture a baseline that has jumped.

The baseline is the mean of the most recent 2^AVG_LOG2 values written into a history buffer. A sample that falls inside the window is written as it is. A sample that falls outside is replaced by the current baseline, so event pulses do not pull the estimate. Each accepted sample produces one result: the sample minus the baseline as a signed value, together with the inside/outside verdict. The current half-width, the current baseline and a settled flag are plain status outputs. The settled flag rises once enough samples have passed for the window to have travelled half of the ADC range.

Samples arrive on a valid/ready stream and results leave on another. The block holds one result. A new sample is taken only when the result register is empty or is being drained in the same cycle. While the consumer holds ready low, the result stays frozen, the input is refused and no internal state moves.

Top module: `baseline_window_tracker`

## Requirements
- R1: After reset the half-width is 1, the baseline is 0, settled is 0, m_valid is 0 and s_ready is 1.
- R2: An accepted sample is inside when its difference d = sample - baseline satisfies -half_width <= d <= half_width. m_diff carries d as a two's-complement value of SAMPLE_W+1 bits, and m_in_window is 1 for inside and 0 for outside.
- R3: The half-width grows by one lsb each time the OUT_LIMIT-th outside sample is counted. The outside count then restarts from zero.
- R4: The half-width shrinks by one lsb each time the IN_LIMIT-th inside sample is counted. Each of the two counts restarts only at its own limit, and neither clears the other.
- R5: The window is two-sided. A sample lying more than half_width below the baseline is outside, and its m_diff is negative.
- R6: The baseline equals the sum of the last 2^AVG_LOG2 values written to the history, shifted right by AVG_LOG2. The history starts as all zeros, gets one write per accepted sample, and does not change without an accepted sample.
- R7: For an outside sample, the value written to the history is the current baseline, not the sample.
- R8: The half-width never drops below 1 and never exceeds 2^(SAMPLE_W-1). A shrink at 1 and a grow at the maximum leave it unchanged.
- R9: settled rises once IN_LIMIT * 2^(SAMPLE_W-1) samples have been accepted since reset, and then stays high.
- R10: A sample is accepted on a clock edge where s_valid and s_ready are both high, with s_ready = !m_valid || m_ready. Its result appears on m_valid/m_diff/m_in_window after that edge and holds while m_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample this cycle |
| s_sample | input | SAMPLE_W | Unsigned ADC sample |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Consumer takes the result |
| m_diff | output | SAMPLE_W+1 | Signed sample minus baseline |
| m_in_window | output | 1 | 1 = baseline sample, 0 = event sample |
| half_width | output | SAMPLE_W | Current window half-width in lsb |
| baseline | output | SAMPLE_W | Current baseline estimate |
| settled | output | 1 | Window has had time to settle |

## Verification
A constant level far from the reset baseline drives the window through a long widen phase, then capture, then a narrow phase down to the floor. This separates the grow and shrink rates and shows that the baseline converges exactly. Samples one and two lsb either side of a settled baseline, plus a deep undershoot, tell a two-sided window from a one-sided one and pin the inclusive edges. A mix of outside and inside samples shows that the inside count cannot clear a partial outside count. A burst of large events checks that the baseline is unmoved, and a saturating run checks the ceiling. A stalled consumer checks that the result and all state hold until the drain.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic {
    CLS_EVENT = 1'b0,
    CLS_BASE  = 1'b1
  } sample_cls_e;
endpackage

// File: rtl/bl_window_ctrl.sv
module bl_window_ctrl #(
  parameter int W         = 12,
  parameter int IN_LIMIT  = 512,
  parameter int OUT_LIMIT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [W-1:0]        sample,
  input  logic [W-1:0]        baseline,
  output logic                in_win,
  output logic signed [W:0]   diff,
  output logic [W-1:0]        half_width
);
  localparam int IN_CW  = $clog2(IN_LIMIT);
  localparam int OUT_CW = $clog2(OUT_LIMIT);
  localparam logic [W-1:0] HW_MIN = W'(1);
  localparam logic [W-1:0] HW_MAX = W'(1) << (W - 1);

  logic [W:0]        mag;
  logic [IN_CW-1:0]  in_cnt;
  logic [OUT_CW-1:0] out_cnt;
  logic              in_hit, out_hit, in_wrap, out_wrap;

  always_comb begin
    diff   = $signed({1'b0, sample}) - $signed({1'b0, baseline});
    mag    = diff[W] ? $unsigned(-diff) : $unsigned(diff);
    in_win = (mag <= {1'b0, half_width});
  end

  assign in_hit   = take && in_win;
  assign out_hit  = take && !in_win;
  assign in_wrap  = in_hit && (in_cnt == IN_CW'(IN_LIMIT - 1));
  assign out_wrap = out_hit && (out_cnt == OUT_CW'(OUT_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt     <= '0;
      out_cnt    <= '0;
      half_width <= HW_MIN;
    end else begin
      if (in_hit)  in_cnt  <= in_wrap  ? '0 : in_cnt + 1'b1;
      if (out_hit) out_cnt <= out_wrap ? '0 : out_cnt + 1'b1;
      if (in_wrap && half_width > HW_MIN)
        half_width <= half_width - 1'b1;
      else if (out_wrap && half_width < HW_MAX)
        half_width <= half_width + 1'b1;
    end
  end

  // R8
  hw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_width >= HW_MIN) && (half_width <= HW_MAX));

  // R3
  grow_only_on_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_win) |=> (half_width >= $past(half_width)));

  // R4
  shrink_only_on_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_win) |=> (half_width <= $past(half_width)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(half_width));
endmodule

// File: rtl/bl_running_avg.sv
module bl_running_avg #(
  parameter int W          = 12,
  parameter int DEPTH_LOG2 = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] push,
  output logic [W-1:0] baseline
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int AW    = W + DEPTH_LOG2;

  logic [W-1:0]          hist [DEPTH];
  logic [DEPTH_LOG2-1:0] ptr;
  logic [AW-1:0]         acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      ptr <= '0;
      acc <= '0;
    end else if (take) begin
      hist[ptr] <= push;
      ptr       <= ptr + 1'b1;
      acc       <= acc + AW'(push) - AW'(hist[ptr]);
    end
  end

  assign baseline = acc[AW-1:DEPTH_LOG2];

  // R6
  avg_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(baseline));
endmodule

// File: rtl/bl_settle_timer.sv
module bl_settle_timer #(
  parameter int unsigned COUNT = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic settled
);
  localparam int CW = $clog2(COUNT + 1);

  logic [CW-1:0] cnt;

  assign settled = (cnt == CW'(COUNT));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (take && !settled) cnt <= cnt + 1'b1;
  end

  // R9
  settled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);
endmodule

// File: rtl/baseline_window_tracker.sv
module baseline_window_tracker #(
  parameter int SAMPLE_W  = 12,
  parameter int IN_LIMIT  = 512,
  parameter int OUT_LIMIT = 64,
  parameter int AVG_LOG2  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [SAMPLE_W-1:0]   s_sample,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [SAMPLE_W:0]     m_diff,
  output logic                  m_in_window,
  output logic [SAMPLE_W-1:0]   half_width,
  output logic [SAMPLE_W-1:0]   baseline,
  output logic                  settled
);
  import bl_pkg::*;

  localparam int unsigned SETTLE_SAMPLES = IN_LIMIT * (2 ** (SAMPLE_W - 1));

  logic                  take, in_win;
  logic signed [SAMPLE_W:0] diff;
  logic [SAMPLE_W-1:0]   push;
  sample_cls_e           cls;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;
  assign cls     = in_win ? CLS_BASE : CLS_EVENT;
  assign push    = (cls == CLS_BASE) ? s_sample : baseline;

  bl_window_ctrl #(.W(SAMPLE_W), .IN_LIMIT(IN_LIMIT), .OUT_LIMIT(OUT_LIMIT)) u_win (
    .clk(clk), .rst_n(rst_n), .take(take), .sample(s_sample), .baseline(baseline),
    .in_win(in_win), .diff(diff), .half_width(half_width)
  );

  bl_running_avg #(.W(SAMPLE_W), .DEPTH_LOG2(AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .take(take), .push(push), .baseline(baseline)
  );

  bl_settle_timer #(.COUNT(SETTLE_SAMPLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .take(take), .settled(settled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid     <= 1'b0;
      m_diff      <= '0;
      m_in_window <= 1'b0;
    end else if (take) begin
      m_valid     <= 1'b1;
      m_diff      <= diff;
      m_in_window <= (cls == CLS_BASE);
    end else if (m_ready) begin
      m_valid     <= 1'b0;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_diff) && $stable(m_in_window)));

  // R10
  no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);
endmodule

// File: tb/tb_baseline_window_tracker.sv
`timescale 1ns/1ps
module tb_baseline_window_tracker;
  localparam int W = 8;
  localparam int INL = 16;
  localparam int OUTL = 4;
  localparam int ALOG = 6;
  localparam int DEPTH = 1 << ALOG;
  localparam int HWMAX = 1 << (W - 1);
  localparam int SETTLE = INL * HWMAX;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, m_ready = 1;
  logic [W-1:0] s_sample = '0;
  logic s_ready, m_valid, m_in_window, settled;
  logic [W:0] m_diff;
  logic [W-1:0] half_width, baseline;

  int checks = 0, fails = 0;
  bit done = 0;

  // independent model state
  int mf[DEPTH];
  int mptr, macc, mbase, mhw, min_c, mout_c, mcnt, mexp_diff, mexp_in;

  always #2 clk = ~clk;

  baseline_window_tracker #(.SAMPLE_W(W), .IN_LIMIT(INL), .OUT_LIMIT(OUTL), .AVG_LOG2(ALOG)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sample(s_sample),
    .m_valid(m_valid), .m_ready(m_ready), .m_diff(m_diff), .m_in_window(m_in_window),
    .half_width(half_width), .baseline(baseline), .settled(settled)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < DEPTH; i++) mf[i] = 0;
    mptr = 0; macc = 0; mbase = 0; mhw = 1; min_c = 0; mout_c = 0; mcnt = 0;
    mexp_diff = 0; mexp_in = 0;
  endfunction

  function automatic void model_step(input int x);
    int d, p;
    d = x - mbase;
    mexp_diff = d;
    mexp_in = (d >= -mhw && d <= mhw) ? 1 : 0;
    p = mexp_in ? x : mbase;
    macc = macc + p - mf[mptr];
    mf[mptr] = p;
    mptr = (mptr + 1) % DEPTH;
    if (mexp_in) begin
      min_c++;
      if (min_c == INL) begin min_c = 0; if (mhw > 1) mhw--; end
    end else begin
      mout_c++;
      if (mout_c == OUTL) begin mout_c = 0; if (mhw < HWMAX) mhw++; end
    end
    mbase = macc >> ALOG;
    if (mcnt < SETTLE) mcnt++;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; s_valid = 0; m_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic send(input int x);
    bit acc;
    @(negedge clk);
    s_valid = 1; s_sample = x[W-1:0];
    #1 acc = s_ready;
    @(posedge clk);
    if (acc) model_step(x);
    #1 s_valid = 0;
  endtask

  task automatic send_n(input int x, input int n);
    for (int i = 0; i < n; i++) send(x);
  endtask

  function automatic int sdiff();
    return $signed(m_diff);
  endfunction

  task automatic cmp_model(input string req);
    chk({req, " hw vs model"}, int'(half_width), mhw);
    chk({req, " baseline vs model"}, int'(baseline), mbase);
    chk({req, " diff vs model"}, sdiff(), mexp_diff);
    chk({req, " inwin vs model"}, int'(m_in_window), mexp_in);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 hw", int'(half_width), 1);
    chk("R1 baseline", int'(baseline), 0);
    chk("R1 settled", int'(settled), 0);
    chk("R1 m_valid", int'(m_valid), 0);
    chk("R1 s_ready", int'(s_ready), 1);
  endtask

  task automatic t_grow();
    do_reset();
    send_n(50, 3);
    @(negedge clk);
    chk("R3 hw after 3 outside", int'(half_width), 1);
    chk("R2 outside flag", int'(m_in_window), 0);
    chk("R2 diff", sdiff(), 50);
    send(50);
    @(negedge clk);
    chk("R3 hw after 4 outside", int'(half_width), 2);
    chk("R7 baseline unchanged by outside", int'(baseline), 0);
    cmp_model("R3");
  endtask

  task automatic t_counters();
    do_reset();
    send_n(50, 3);
    send_n(0, 20);
    @(negedge clk);
    chk("R8 hw floor after shrink", int'(half_width), 1);
    chk("R2 inside flag", int'(m_in_window), 1);
    send(50);
    @(negedge clk);
    chk("R4 outside count kept across inside", int'(half_width), 2);
    cmp_model("R4");
  endtask

  task automatic t_track();
    do_reset();
    send_n(60, 1500);
    @(negedge clk);
    chk("R6 baseline converges", int'(baseline), 60);
    chk("R4 hw narrowed to floor", int'(half_width), 1);
    chk("R2 diff zero on baseline", sdiff(), 0);
    chk("R2 inside on baseline", int'(m_in_window), 1);
    cmp_model("R6");
  endtask

  task automatic t_two_sided();
    // continues from t_track: baseline 60, hw 1
    send(61); @(negedge clk);
    chk("R2 +1 edge inside", int'(m_in_window), 1);
    chk("R2 +1 diff", sdiff(), 1);
    send(59); @(negedge clk);
    chk("R5 -1 edge inside", int'(m_in_window), 1);
    chk("R5 -1 diff", sdiff(), -1);
    send(62); @(negedge clk);
    chk("R2 +2 outside", int'(m_in_window), 0);
    send(58); @(negedge clk);
    chk("R5 -2 outside", int'(m_in_window), 0);
    chk("R5 -2 diff", sdiff(), -2);
    send(30); @(negedge clk);
    chk("R5 deep undershoot outside", int'(m_in_window), 0);
    chk("R5 deep undershoot diff", sdiff(), -30);
    cmp_model("R5");
  endtask

  task automatic t_replace();
    send_n(200, 10);
    @(negedge clk);
    chk("R7 baseline unmoved by events", int'(baseline), 60);
    chk("R7 diff of event", sdiff(), 140);
    cmp_model("R7");
  endtask

  task automatic t_saturate();
    do_reset();
    send_n(255, 700);
    @(negedge clk);
    chk("R8 hw ceiling", int'(half_width), HWMAX);
    chk("R8 baseline stays", int'(baseline), 0);
    cmp_model("R8");
  endtask

  task automatic t_settle();
    do_reset();
    send_n(0, SETTLE - 1);
    @(negedge clk);
    chk("R9 not settled one short", int'(settled), 0);
    send(0);
    @(negedge clk);
    chk("R9 settled at count", int'(settled), 1);
    send_n(200, 5);
    @(negedge clk);
    chk("R9 settled sticky", int'(settled), 1);
  endtask

  task automatic t_backpressure();
    int hw0, b0;
    do_reset();
    send_n(60, 20);
    @(negedge clk);
    m_ready = 0;
    send(100);
    @(negedge clk);
    hw0 = int'(half_width); b0 = int'(baseline);
    chk("R10 result valid", int'(m_valid), 1);
    s_valid = 1; s_sample = 7;
    #1 chk("R10 s_ready low when full", int'(s_ready), 0);
    repeat (3) @(negedge clk);
    chk("R10 diff held", sdiff(), 100 - mbase + (mexp_diff - (100 - mbase)));
    chk("R10 diff held value", sdiff(), mexp_diff);
    chk("R10 hw untouched while stalled", int'(half_width), hw0);
    chk("R10 baseline untouched while stalled", int'(baseline), b0);
    m_ready = 1;
    #1 chk("R10 s_ready on drain", int'(s_ready), 1);
    @(posedge clk);
    model_step(7);
    #1 s_valid = 0;
    @(negedge clk);
    chk("R10 next result", sdiff(), mexp_diff);
    cmp_model("R10");
  endtask

  initial begin
    t_reset();
    t_grow();
    t_counters();
    t_track();
    t_two_sided();
    t_replace();
    t_saturate();
    t_settle();
    t_backpressure();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule